// File: doc/BRIEF.md
# Prioritized Interrupt Level Evaluator

This block decides whether a processor core should take an interrupt. It keeps a software request register and a current priority level register, both written through simple write ports. It also watches a vector of external interrupt lines. Both kinds of source are merged onto one priority scale:

- A software request at bit `i` ranks at level `i - 3`.
- An external line `j` ranks at a fixed level `20 + j`, which is above every software level.

Each cycle the block is enabled and armed, it finds the highest pending level and builds a summary vector with one bit per pending source. If that level is above the current priority level, it emits a one-cycle take strobe and latches the summary and the level into its output registers.

After it takes an interrupt, the block disarms itself. It evaluates again only after a return-from-exception pulse re-arms it. Fetching the handler vector is left to the surrounding core.

Top module: `irq_level_eval`

## Requirements
- R1: After reset, the software request register, current level, summary and interrupt ID are all zero, `intTake` is low, and the block is armed.
- R2: A write to the software request register keeps only bits 4 to 18 of the written word (mask 0x7FFF0). The stored value is visible on `swReq`.
- R3: A write to the current level register keeps only the low 5 bits. The stored value is visible on `curLevel`.
- R4: A pending software request at bit `i` (4..18) ranks at level `i - 3`, giving levels 1 to 15.
- R5: Every pending source sets its own bit in the summary:
  - software bit `i` sets summary bit `i`;
  - external line `j` sets summary bit `20 + j`.
  The highest pending source decides the level.
- R6: External line `j` (0..4) ranks at level `20 + j` and overrides any pending software level.
- R7: An interrupt is taken only when the pending level is nonzero and strictly greater than `curLevel`.
- R8: When an interrupt is taken at a clock edge:
  - `intTake` is high for exactly the following cycle;
  - `intSummary` and `intId` take the summary and the level at that same edge;
  - otherwise both hold their values.
- R9: Evaluation happens only while `evalEn` is high and the block is armed. Taking an interrupt disarms the block, and an `rfe` pulse re-arms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swWe | input | 1 | Write strobe for the software request register |
| swWdata | input | 32 | Write data for the software request register |
| lvlWe | input | 1 | Write strobe for the current level register |
| lvlWdata | input | 32 | Write data for the current level register |
| extLines | input | 5 | External interrupt lines, active high |
| evalEn | input | 1 | Evaluation enable |
| rfe | input | 1 | Return-from-exception pulse; re-arms evaluation |
| swReq | output | 32 | Stored software request register |
| curLevel | output | 5 | Stored current priority level |
| intTake | output | 1 | One-cycle take-interrupt strobe |
| intSummary | output | 25 | Latched summary of pending sources |
| intId | output | 5 | Latched interrupt level |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:

- **Pending level equal to the current level.** A design using a non-strict compare would take an interrupt here that it must not take.
- **All fifteen software bits pending.** A design that scans in the wrong direction would report level 1 instead of 15.
- **External lines together with software requests.** An encoder with the wrong merge order would let software win.
- **Writes carrying junk bits.** A design with a missing mask would leak those bits into `swReq` or `curLevel`.
- **Repeated evaluation without `rfe`, and with `evalEn` low.** A design that never disarms, or ignores the enable, would pulse `intTake` again.
- **Summary and ID after a non-taken evaluation.** A design that latches unconditionally would change them when no interrupt was taken.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic latchEn;   // capture summary and level this edge
  } irq_ctl_t;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath #(
  parameter int DATA_W         = 32,
  parameter int SW_LO          = 4,
  parameter int SW_N           = 15,
  parameter int EXT_N          = 5,
  parameter int EXT_SUM_LO     = 20,
  parameter int EXT_LEVEL_BASE = 20,
  parameter int LVL_W          = 5,
  localparam int SUM_W         = EXT_SUM_LO + EXT_N
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 swWe,
  input  logic [DATA_W-1:0]    swWdata,
  input  logic                 lvlWe,
  input  logic [DATA_W-1:0]    lvlWdata,
  input  logic [EXT_N-1:0]     extLines,
  input  irq_pkg::irq_ctl_t    ctl,
  output logic                 above,
  output logic [DATA_W-1:0]    swReq,
  output logic [LVL_W-1:0]     curLevel,
  output logic [SUM_W-1:0]     intSummary,
  output logic [LVL_W-1:0]     intId
);
  localparam logic [DATA_W-1:0] SW_MASK = ((DATA_W'(1) << SW_N) - DATA_W'(1)) << SW_LO;

  logic [LVL_W-1:0] pendLevel;
  logic [SUM_W-1:0] pendSum;

  // Priority scan: software first, then external; the last set source wins
  always_comb begin
    pendLevel = '0;
    pendSum   = '0;
    for (int i = 0; i < SW_N; i++) begin
      if (swReq[SW_LO+i]) begin
        pendLevel        = LVL_W'(i + 1);
        pendSum[SW_LO+i] = 1'b1;
      end
    end
    for (int j = 0; j < EXT_N; j++) begin
      if (extLines[j]) begin
        pendLevel             = LVL_W'(EXT_LEVEL_BASE + j);
        pendSum[EXT_SUM_LO+j] = 1'b1;
      end
    end
  end

  assign above = (pendLevel != '0) && (pendLevel > curLevel);

  always_ff @(posedge clk) begin
    if (rst) begin
      swReq      <= '0;
      curLevel   <= '0;
      intSummary <= '0;
      intId      <= '0;
    end else begin
      if (swWe)  swReq    <= swWdata & SW_MASK;
      if (lvlWe) curLevel <= lvlWdata[LVL_W-1:0];
      if (ctl.latchEn) begin
        intSummary <= pendSum;
        intId      <= pendLevel;
      end
    end
  end
endmodule

// File: rtl/irq_control.sv
module irq_control (
  input  logic               clk,
  input  logic               rst,
  input  logic               evalEn,
  input  logic               rfe,
  input  logic               above,
  output irq_pkg::irq_ctl_t  ctl,
  output logic               intTake
);
  logic armed;
  logic takeNow;

  assign takeNow     = evalEn && armed && above;
  assign ctl.latchEn = takeNow;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b1;
      intTake <= 1'b0;
    end else begin
      intTake <= takeNow;
      if (takeNow)  armed <= 1'b0;
      else if (rfe) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_level_eval.sv
module irq_level_eval #(
  parameter int DATA_W         = 32,
  parameter int SW_LO          = 4,
  parameter int SW_N           = 15,
  parameter int EXT_N          = 5,
  parameter int EXT_SUM_LO     = 20,
  parameter int EXT_LEVEL_BASE = 20,
  parameter int LVL_W          = 5,
  localparam int SUM_W         = EXT_SUM_LO + EXT_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              swWe,
  input  logic [DATA_W-1:0] swWdata,
  input  logic              lvlWe,
  input  logic [DATA_W-1:0] lvlWdata,
  input  logic [EXT_N-1:0]  extLines,
  input  logic              evalEn,
  input  logic              rfe,
  output logic [DATA_W-1:0] swReq,
  output logic [LVL_W-1:0]  curLevel,
  output logic              intTake,
  output logic [SUM_W-1:0]  intSummary,
  output logic [LVL_W-1:0]  intId
);
  irq_pkg::irq_ctl_t ctl;
  logic above;

  irq_datapath #(
    .DATA_W(DATA_W), .SW_LO(SW_LO), .SW_N(SW_N), .EXT_N(EXT_N),
    .EXT_SUM_LO(EXT_SUM_LO), .EXT_LEVEL_BASE(EXT_LEVEL_BASE), .LVL_W(LVL_W)
  ) u_dp (
    .clk(clk), .rst(rst), .swWe(swWe), .swWdata(swWdata),
    .lvlWe(lvlWe), .lvlWdata(lvlWdata), .extLines(extLines),
    .ctl(ctl), .above(above), .swReq(swReq), .curLevel(curLevel),
    .intSummary(intSummary), .intId(intId)
  );

  irq_control u_ctl (
    .clk(clk), .rst(rst), .evalEn(evalEn), .rfe(rfe),
    .above(above), .ctl(ctl), .intTake(intTake)
  );
endmodule

// File: rtl/irq_level_eval_chk.sv
module irq_level_eval_chk #(
  parameter int DATA_W = 32,
  parameter int SUM_W  = 25,
  parameter int LVL_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] swReq,
  input logic [LVL_W-1:0]  curLevel,
  input logic              intTake,
  input logic [SUM_W-1:0]  intSummary,
  input logic [LVL_W-1:0]  intId
);
  // R7
  take_above_level_chk: assert property (@(posedge clk) disable iff (rst)
    intTake |-> (intId > $past(curLevel)));

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !intTake |-> ($stable(intSummary) && $stable(intId)));

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    intTake |=> !intTake);

  // R5
  summary_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    intTake |-> (intSummary != '0));

  // R2
  sw_low_bits_clear_chk: assert property (@(posedge clk) disable iff (rst)
    swReq[3:0] == 4'h0);
endmodule

bind irq_level_eval irq_level_eval_chk #(
  .DATA_W(DATA_W), .SUM_W(SUM_W), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst(rst), .swReq(swReq), .curLevel(curLevel),
  .intTake(intTake), .intSummary(intSummary), .intId(intId)
);

// File: tb/irq_level_eval_bench.sv
module irq_level_eval_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        swWe, lvlWe, evalEn, rfe;
  logic [31:0] swWdata, lvlWdata;
  logic [4:0]  extLines;
  logic [31:0] swReq;
  logic [4:0]  curLevel;
  logic        intTake;
  logic [24:0] intSummary;
  logic [4:0]  intId;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic        take;
    logic [24:0] sum;
    logic [4:0]  id;
    string       tag;
  } exp_t;
  exp_t expQ[$];
  event chkEv;
  event doneEv;

  // model state
  logic [24:0] mSum = '0;
  logic [4:0]  mId = '0;
  logic        mArmed = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_level_eval u_irq_level_eval (
    .clk(clk), .rst(rst), .swWe(swWe), .swWdata(swWdata),
    .lvlWe(lvlWe), .lvlWdata(lvlWdata), .extLines(extLines),
    .evalEn(evalEn), .rfe(rfe), .swReq(swReq), .curLevel(curLevel),
    .intTake(intTake), .intSummary(intSummary), .intId(intId)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per check event
  initial begin
    forever begin
      @(chkEv);
      if (expQ.size() != 0) begin
        exp_t e;
        e = expQ.pop_front();
        check({e.tag, " take"}, 32'(intTake), 32'(e.take));
        check({e.tag, " sum"},  32'(intSummary), 32'(e.sum));
        check({e.tag, " id"},   32'(intId), 32'(e.id));
      end
      -> doneEv;
    end
  end

  // Reference ranking from the requirements
  function automatic void rank(input logic [31:0] sw, input logic [4:0] ext,
                               output logic [4:0] lvl, output logic [24:0] sum);
    lvl = '0; sum = '0;
    for (int i = 4; i <= 18; i++)
      if (sw[i]) begin lvl = 5'(i - 3); sum[i] = 1'b1; end
    for (int j = 0; j < 5; j++)
      if (ext[j]) begin lvl = 5'(20 + j); sum[20+j] = 1'b1; end
  endfunction

  task automatic runCase(input string tag, input logic [31:0] sw, input logic [4:0] ext,
                         input logic [31:0] ipl, input logic en, input logic doRfe);
    logic [4:0]  lvl;
    logic [24:0] sum;
    logic        tk;
    exp_t        e;
    @(negedge clk);
    swWe = 1; swWdata = sw; lvlWe = 1; lvlWdata = ipl; extLines = ext; evalEn = 0;
    @(negedge clk);
    swWe = 0; lvlWe = 0; evalEn = en;
    rank(sw & 32'h7FFF0, ext, lvl, sum);
    tk = en && mArmed && (lvl != 0) && (lvl > ipl[4:0]);
    if (tk) begin mSum = sum; mId = lvl; mArmed = 0; end
    e.take = tk; e.sum = mSum; e.id = mId; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    evalEn = 0;
    -> chkEv; @(doneEv);
    @(negedge clk);
    check({tag, " pulse ends"}, 32'(intTake), 32'h0);  // R8
    if (doRfe) begin
      rfe = 1; @(negedge clk); rfe = 0; mArmed = 1;
    end
  endtask

  initial begin
    rst = 1; swWe = 0; lvlWe = 0; evalEn = 0; rfe = 0;
    swWdata = '0; lvlWdata = '0; extLines = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 swReq", swReq, 32'h0);
    check("R1 curLevel", 32'(curLevel), 32'h0);
    check("R1 intTake", 32'(intTake), 32'h0);
    check("R1 sum", 32'(intSummary), 32'h0);
    check("R1 id", 32'(intId), 32'h0);

    // R2 mask on software write
    swWe = 1; swWdata = 32'hFFFF_FFFF; @(negedge clk); swWe = 0;
    check("R2 swReq mask", swReq, 32'h0007_FFF0);
    // R3 mask on level write
    lvlWe = 1; lvlWdata = 32'h0000_00FF; @(negedge clk); lvlWe = 0;
    check("R3 curLevel mask", 32'(curLevel), 32'd31);

    runCase("R4 lowest sw bit", 32'h10, 5'h0, 0, 1, 1);
    runCase("R4 R5 all sw bits", 32'hFFFF_FFFF, 5'h0, 14, 1, 1);
    runCase("R7 equal level", 32'h4_0000, 5'h0, 15, 1, 1);
    runCase("R7 level via masked write", 32'h4_0000, 5'h0, 32'h2E, 1, 1);
    runCase("R6 ext over sw", 32'h7FFF0, 5'h01, 5, 1, 1);
    runCase("R6 top ext", 32'h0, 5'h1F, 23, 1, 1);
    runCase("R7 ext not above", 32'h0, 5'h10, 24, 1, 1);
    runCase("R7 nothing pending", 32'h0, 5'h0, 0, 1, 1);
    runCase("R9 evalEn low", 32'h100, 5'h0, 0, 0, 1);
    runCase("R9 take then disarm", 32'h800, 5'h0, 0, 1, 0);
    runCase("R9 disarmed", 32'h0, 5'h04, 0, 1, 1);
    runCase("R9 rearmed", 32'h0, 5'h04, 0, 1, 1);
    runCase("R5 mixed sum", 32'h0001_0220, 5'h0A, 3, 1, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule